// File: doc/BRIEF.md
# V.23 FSK Transmit Modulator

This block turns a serial transmit data bit into a sampled sine wave for a V.23 modem line. A 24-bit phase accumulator advances once per 8 kHz sample strobe. The top bits of the phase address a 256-point sine table. The unsigned 8-bit result goes to a digital-to-analog converter, and a one-cycle valid strobe marks each new sample.

A two-bit channel code chooses one of three settings: modulator off, the 75 bps return channel, or the 1200 bps forward channel. A separate path-select input hands the output stage to a tone generator that lies outside this block. While that path is selected, and whenever the channel code is off, the block parks its output at midscale and clears its phase. The data bit chooses the mark or the space tone of the selected channel. A change of tone alters only the phase step, so the waveform stays continuous across bit boundaries.

Top module: `fskTxModulator`

## Requirements
- R1: While `rstN` is low, `sampleOut` is 128, `sampleValid` is 0 and the phase is zero. After reset is released, the first active sample is therefore 128.
- R2: A strobe taken with `toneSel` = 1 makes the next `sampleOut` exactly 128 and clears the phase. The first active sample after that is 128 again.
- R3: A strobe taken with `modeSel[1]` = 0 (codes 00 and 01) parks the output at exactly 128 and clears the phase, whatever `modeSel[0]` and `txBit` hold.
- R4: With `modeSel` = 10, each strobe adds 943718 (450 Hz, `txBit` = 0) or 817889 (390 Hz, `txBit` = 1) to the phase. Each step is round(f·2^24/8000).
- R5: With `modeSel` = 11, each strobe adds 4404019 (2100 Hz, `txBit` = 0) or 2726298 (1300 Hz, `txBit` = 1) to the phase.
- R6: The phase wraps modulo 2^24. The sample produced on a strobe uses index k, the top 8 bits of the phase before that strobe's addition. Its value lies within 1 of 128 + 127·sin(2πk/256), so it is never 0.
- R7: A change of `txBit` or of the active channel changes only the step size. The phase carries on from its current value.
- R8: `modeSel`, `toneSel` and `txBit` are sampled only in the clock cycle where `sampleStb` is 1. `sampleOut` does not change in any other cycle.
- R9: `sampleValid` is 1 in exactly the cycle after each cycle with `sampleStb` = 1, and 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | One-cycle pulse at the output sample rate (8 kHz) |
| modeSel | input | 2 | Channel code: 0x off, 10 low-rate channel, 11 high-rate channel |
| toneSel | input | 1 | 1 selects the external tone path; this block then idles at midscale |
| txBit | input | 1 | Transmit data: 1 mark, 0 space |
| sampleOut | output | 8 | Unsigned sine sample, midscale 128 |
| sampleValid | output | 1 | Pulses for one cycle when a new sample is presented |

## Verification
A wrong phase step or a wrong increment choice shows up one strobe later as a sample that departs from the reference sine index. The error then grows with every later strobe, so a short run of samples in each mode exposes it. A phase that is not cleared on parking shows at the first active sample after the park, which must be exactly midscale. Inputs that leak outside the strobe cycle show as a `sampleOut` that moves between strobes, or as a next sample that tracks the transient setting instead of the restored one.

// File: rtl/fskTxPkg.sv
package fskTxPkg;

  // Channel codes carried on the two mode bits
  typedef enum logic [1:0] {
    CH_OFF_A = 2'b00,
    CH_OFF_B = 2'b01,
    CH_LOW   = 2'b10,
    CH_HIGH  = 2'b11
  } fskChannel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic stepEn;   // advance phase and emit a sine sample
    logic parkEn;   // clear phase and emit midscale
    logic selHigh;  // high-rate channel tone pair
    logic selMark;  // mark tone of the pair
  } fskCtrlBus_t;

  // Phase step for a tone: round(freq * 2^accW / fs)
  function automatic longint phaseStep(input longint freqHz, input int accW, input longint fsHz);
    longint scaled;
    scaled = (freqHz <<< accW) + (fsHz / 2);
    return scaled / fsHz;
  endfunction

endpackage

// File: rtl/fskTxCtrl.sv
module fskTxCtrl
  import fskTxPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleStb,
  input  logic [1:0]  modeSel,
  input  logic        toneSel,
  input  logic        txBit,
  output fskCtrlBus_t ctrlBus,
  output logic        sampleValid
);

  fskChannel_e channel;
  logic        fskActive;

  always_comb begin
    channel   = fskChannel_e'(modeSel);
    fskActive = !toneSel && ((channel == CH_LOW) || (channel == CH_HIGH));
  end

  // All inputs are consumed only in the strobe cycle
  always_comb begin
    ctrlBus.stepEn  = sampleStb && fskActive;
    ctrlBus.parkEn  = sampleStb && !fskActive;
    ctrlBus.selHigh = (channel == CH_HIGH);
    ctrlBus.selMark = txBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) sampleValid <= 1'b0;
    else       sampleValid <= sampleStb;
  end

endmodule

// File: rtl/fskTxDatapath.sv
module fskTxDatapath
  import fskTxPkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int IDX_W      = 8,
  parameter int OUT_W      = 8,
  parameter int FS_HZ      = 8000,
  parameter int LO_SPACE_HZ = 450,
  parameter int LO_MARK_HZ  = 390,
  parameter int HI_SPACE_HZ = 2100,
  parameter int HI_MARK_HZ  = 1300
) (
  input  logic             clk,
  input  logic             rstN,
  input  fskCtrlBus_t      ctrlBus,
  output logic [OUT_W-1:0] sampleOut
);

  localparam int LUT_DEPTH = 1 << IDX_W;
  localparam int HALF_DEPTH = LUT_DEPTH / 2;
  localparam int MID_CODE  = 1 << (OUT_W - 1);
  localparam int AMP_CODE  = MID_CODE - 1;
  localparam logic [OUT_W-1:0] MID_OUT = OUT_W'(MID_CODE);

  // Step table indexed by {selHigh, selMark}
  localparam logic [ACC_W-1:0] STEP_TAB [4] = '{
    ACC_W'(phaseStep(LO_SPACE_HZ, ACC_W, FS_HZ)),
    ACC_W'(phaseStep(LO_MARK_HZ,  ACC_W, FS_HZ)),
    ACC_W'(phaseStep(HI_SPACE_HZ, ACC_W, FS_HZ)),
    ACC_W'(phaseStep(HI_MARK_HZ,  ACC_W, FS_HZ))
  };

  // Rational sine approximation per half cycle, pi mapped to HALF_DEPTH
  function automatic longint sineEntry(input int k);
    longint h, p, den, mag;
    h   = longint'(k % HALF_DEPTH);
    p   = h * (HALF_DEPTH - h);
    den = 5 * HALF_DEPTH * HALF_DEPTH - 4 * p;
    mag = (AMP_CODE * 16 * p + den / 2) / den;
    if (k < HALF_DEPTH) return MID_CODE + mag;
    else                return MID_CODE - mag;
  endfunction

  logic [OUT_W-1:0] sineLut [LUT_DEPTH];

  for (genvar k = 0; k < LUT_DEPTH; k++) begin : g_lut
    assign sineLut[k] = OUT_W'(sineEntry(k));
  end

  logic [ACC_W-1:0] phaseAcc;
  logic [ACC_W-1:0] stepSel;
  logic [IDX_W-1:0] lutIdx;

  always_comb begin
    stepSel = STEP_TAB[{ctrlBus.selHigh, ctrlBus.selMark}];
    lutIdx  = phaseAcc[ACC_W-1 -: IDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc  <= '0;
      sampleOut <= MID_OUT;
    end else if (ctrlBus.parkEn) begin
      phaseAcc  <= '0;
      sampleOut <= MID_OUT;
    end else if (ctrlBus.stepEn) begin
      phaseAcc  <= phaseAcc + stepSel;
      sampleOut <= sineLut[lutIdx];
    end
  end

endmodule

// File: rtl/fskTxModulator.sv
module fskTxModulator
  import fskTxPkg::*;
#(
  parameter int ACC_W = 24,
  parameter int IDX_W = 8,
  parameter int OUT_W = 8,
  parameter int FS_HZ = 8000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStb,
  input  logic [1:0]       modeSel,
  input  logic             toneSel,
  input  logic             txBit,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid
);

  fskCtrlBus_t ctrlBus;

  fskTxCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleStb  (sampleStb),
    .modeSel    (modeSel),
    .toneSel    (toneSel),
    .txBit      (txBit),
    .ctrlBus    (ctrlBus),
    .sampleValid(sampleValid)
  );

  fskTxDatapath #(
    .ACC_W(ACC_W),
    .IDX_W(IDX_W),
    .OUT_W(OUT_W),
    .FS_HZ(FS_HZ)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlBus  (ctrlBus),
    .sampleOut(sampleOut)
  );

endmodule

// File: rtl/fskTxModulatorChk.sv
module fskTxModulatorChk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleStb,
  input logic [1:0]       modeSel,
  input logic             toneSel,
  input logic             txBit,
  input logic [OUT_W-1:0] sampleOut,
  input logic             sampleValid
);

  localparam logic [OUT_W-1:0] MID_OUT = OUT_W'(1 << (OUT_W - 1));

  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> sampleValid); // R9

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> !sampleValid); // R9

  AST_TONE_PATH_PARK: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && toneSel) |=> (sampleOut == MID_OUT)); // R2

  AST_MODE_OFF_PARK: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && !modeSel[1]) |=> (sampleOut == MID_OUT)); // R3

  AST_HOLD_BETWEEN_STB: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> $stable(sampleOut)); // R8

  AST_SAMPLE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleOut != '0)); // R6

  AST_TXBIT_DONTCARE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && !modeSel[1] && txBit) |=> (sampleOut == MID_OUT)); // R3

endmodule

bind fskTxModulator fskTxModulatorChk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleStb  (sampleStb),
  .modeSel    (modeSel),
  .toneSel    (toneSel),
  .txBit      (txBit),
  .sampleOut  (sampleOut),
  .sampleValid(sampleValid)
);

// File: tb/fskTxModulator_test.sv
module fskTxModulator_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleStb = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       toneSel = 1'b0;
  logic       txBit = 1'b0;
  logic [7:0] sampleOut;
  logic       sampleValid;

  int checks = 0;
  int fails  = 0;
  longint mPhase = 0;  // bench model of the 24-bit phase

  always #5 clk = ~clk;

  fskTxModulator uut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .modeSel(modeSel),
    .toneSel(toneSel), .txBit(txBit), .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  // {mode, tone, bit, strobes, requirement number}
  typedef struct packed {
    logic [1:0] mode;
    logic       tone;
    logic       bitv;
    logic [7:0] count;
    logic [3:0] req;
  } vec_t;

  localparam int VEC_N = 10;
  localparam vec_t VECS [VEC_N] = '{
    '{2'b10, 1'b0, 1'b0, 8'd6, 4'd4},  // R4 low channel space
    '{2'b10, 1'b0, 1'b1, 8'd6, 4'd4},  // R4 low channel mark, continuous (R7)
    '{2'b11, 1'b0, 1'b0, 8'd9, 4'd5},  // R5 high space, wraps phase (R6)
    '{2'b11, 1'b0, 1'b1, 8'd7, 4'd5},  // R5 high mark
    '{2'b10, 1'b0, 1'b0, 8'd4, 4'd7},  // R7 channel switch keeps phase
    '{2'b11, 1'b1, 1'b0, 8'd2, 4'd2},  // R2 tone path parks
    '{2'b11, 1'b0, 1'b1, 8'd5, 4'd2},  // R2 restart from zero phase
    '{2'b00, 1'b0, 1'b1, 8'd3, 4'd3},  // R3 off code 00
    '{2'b01, 1'b0, 1'b0, 8'd3, 4'd3},  // R3 off code 01
    '{2'b10, 1'b0, 1'b1, 8'd4, 4'd3}   // R3 restart after off
  };

  function automatic longint stepRef(input logic hi, input logic mark);
    if (!hi) return mark ? 64'd817889 : 64'd943718;
    else     return mark ? 64'd2726298 : 64'd4404019;
  endfunction

  task automatic checkVal(input string tag, input int act, input real expv, input real tol);
    real d;
    checks++;
    d = act - expv;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0.2f", tag, act, expv);
    end
  endtask

  // Expected next sample from the bench model, then advance the model
  function automatic real modelStep();
    real expv;
    longint k;
    if (toneSel || !modeSel[1]) begin
      mPhase = 0;
      return 128.0;
    end
    k = (mPhase >> 16) & 64'hFF;
    expv = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 256.0);
    mPhase = (mPhase + stepRef(modeSel[0], txBit)) & 64'hFFFFFF;
    return expv;
  endfunction

  task automatic strobeAndCheck(input string tag);
    real expv;
    int  held;
    bit  exact;
    exact = toneSel || !modeSel[1];
    @(negedge clk) sampleStb = 1'b1;
    expv = modelStep();
    @(negedge clk) sampleStb = 1'b0;
    checkVal(tag, int'(sampleOut), expv, exact ? 0.0 : 1.0);
    checkVal("R9 valid after strobe", int'(sampleValid), 1.0, 0.0);
    held = int'(sampleOut);
    @(negedge clk);
    checkVal("R9 valid single cycle", int'(sampleValid), 0.0, 0.0);
    checkVal("R8 hold between strobes", int'(sampleOut), real'(held), 0.0);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int held;
    // R1 reset state
    repeat (3) @(negedge clk);
    checkVal("R1 reset output", int'(sampleOut), 128.0, 0.0);
    checkVal("R1 reset valid", int'(sampleValid), 0.0, 0.0);
    @(negedge clk) rstN = 1'b1;

    for (int v = 0; v < VEC_N; v++) begin
      @(negedge clk);
      modeSel = VECS[v].mode;
      toneSel = VECS[v].tone;
      txBit   = VECS[v].bitv;
      for (int s = 0; s < int'(VECS[v].count); s++)
        strobeAndCheck($sformatf("R%0d vector %0d sample %0d", VECS[v].req, v, s));
    end

    // R8: inputs toggled between strobes have no effect
    modeSel = 2'b11; toneSel = 1'b0; txBit = 1'b0;
    strobeAndCheck("R8 baseline");
    held = int'(sampleOut);
    @(negedge clk) begin txBit = 1'b1; modeSel = 2'b00; toneSel = 1'b1; end
    @(negedge clk);
    checkVal("R8 ignore inputs without strobe", int'(sampleOut), real'(held), 0.0);
    @(negedge clk);
    checkVal("R8 no valid without strobe", int'(sampleValid), 0.0, 0.0);
    modeSel = 2'b11; toneSel = 1'b0; txBit = 1'b0;
    strobeAndCheck("R8 sample after restored inputs");
    strobeAndCheck("R8 phase unaffected");

    // R1: reset in the middle of a run clears phase
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    checkVal("R1 reset mid-run output", int'(sampleOut), 128.0, 0.0);
    checkVal("R1 reset mid-run valid", int'(sampleValid), 0.0, 0.0);
    @(negedge clk) rstN = 1'b1;
    mPhase = 0;
    modeSel = 2'b11; txBit = 1'b1;
    strobeAndCheck("R1 first sample after reset");
    @(negedge clk);
    checkVal("R1 first sample midscale", int'(sampleOut), 128.0, 0.0);
    strobeAndCheck("R1 second sample after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule